// File: doc/BRIEF.md
# Dynamic Bus Sizing Access Sequencer

This block converts accesses from an internal 32-bit request port into transfers on an external multiplexed data bus whose attached device may be 8, 16 or 32 bits wide. With each request it captures the configuration of the selected chip-select: a port-width code, a lane-placement bit, a byte-enable-on-read bit, and separate burst enables for reads and writes. An access wider than the port becomes several port-sized beats. These beats run either as independent transfers or as one burst. Write bytes are steered onto the external byte lanes that the port occupies, and read bytes are gathered back into a right-aligned 32-bit result.

Every beat waits for a ready (acknowledge) from the external side. The block issues a transfer-start strobe, a burst indicator and per-lane byte strobes. After the final beat it returns one completion pulse. Request data is right-aligned: a byte access uses bits 7:0 and a word access uses bits 15:0. Bytes are numbered from the most significant end of the access, so byte 0 is the most significant byte.

Top module: `dbs_sequencer`

## Requirements
- R1: A port-width code of 00 selects a 32-bit port: a longword access completes in one beat with all four strobes and the whole 32-bit data bus in use. Lane i is `bus_dout[8i+7:8i]` / `bus_din[8i+7:8i]`, and its strobe is `bus_be[i]`.
- R2: Code 01 selects an 8-bit port. With the lane-placement bit at 0 it uses lane 3 (bits 31:24). With the bit at 1 it uses lane 0 (bits 7:0).
- R3: Codes 10 and 11 both select a 16-bit port. With the lane-placement bit at 0 it uses lanes 3 and 2 (bits 31:16). With the bit at 1 it uses lanes 1 and 0 (bits 15:0).
- R4: An access wider than the port, with the burst enable for its direction cleared, runs as separate beats. The burst indicator stays low, and the start strobe is high in the first cycle of every beat and low in the other cycles.
- R5: An access wider than the port, with the burst enable for its direction set, runs as one burst. The burst indicator stays high in every cycle of every beat, and the start strobe is high only in the first cycle of the first beat.
- R6: Reads follow only the read burst enable and writes follow only the write burst enable.
- R7: With byte-enable-on-read at 0, the strobes stay at 0 during read beats. With it at 1, reads drive the strobes of the lanes in use. Writes always drive the strobes of the lanes in use.
- R8: Beats transfer access bytes from most significant to least significant. The beat address starts at the request address and grows by the port width in bytes on each beat.
- R9: The cycle after the acknowledge of the last beat, `done` is high for exactly one cycle. During that cycle `rdata` holds the assembled read value, right-aligned and zero-extended, or zero after a write.
- R10: An access no wider than the port takes one beat with the burst indicator low, whatever the burst enables. The access occupies the port bytes at offset (address mod port width), rounded down to the access size. Port byte 0 is the port's most significant lane.
- R11: Lanes not in use carry zero data and a cleared strobe, reads drive zero write data, and outside a beat (`bus_cyc` low) the start, burst and strobe outputs are low.
- R12: After reset the block is idle: `req_ready` is high and `bus_cyc`, `done` and `bus_be` are low. It accepts a request only while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 00 byte, 01 word, 10/11 longword |
| req_wdata | input | 32 | Right-aligned write data |
| cfg_port_size | input | 2 | Port width code of the selected chip-select |
| cfg_lane_low | input | 1 | Narrow port on low lanes when 1 |
| cfg_be_on_read | input | 1 | Strobes also asserted on reads |
| cfg_burst_rd | input | 1 | Burst enable for reads |
| cfg_burst_wr | input | 1 | Burst enable for writes |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data, valid with done |
| bus_cyc | output | 1 | Beat in progress |
| bus_start | output | 1 | Transfer start strobe |
| bus_burst | output | 1 | Burst in progress |
| bus_rnw | output | 1 | 1 = read beat |
| bus_addr | output | ADDR_W | Beat address |
| bus_dout | output | 32 | Write data on external lanes |
| bus_din | input | 32 | Read data from external lanes |
| bus_be | output | 4 | Byte / write-enable strobes per lane |
| bus_ack | input | 1 | External ready, ends the current beat |

## Verification
Some properties are checked in every cycle: the start strobe never appears outside a beat, and it never repeats after the first cycle of a burst. Read strobes stay clear when reads do not enable them. Completion is a single pulse that always follows an acknowledged beat. The bus outputs stay quiet whenever the sequencer is idle. Other behaviour can only be shown by the bench scenarios, which compare each beat against expectations computed per port width and lane placement. These cover which lanes carry which bytes and in what order, the beat count chosen by the direction's burst enable, the address step, the lane offset of narrow accesses, and the value of the assembled read.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = LANES * 8;
    localparam int BEAT_W = $clog2(LANES);

    typedef enum logic [1:0] {
        ACC_BYTE     = 2'b00,
        ACC_WORD     = 2'b01,
        ACC_LONG     = 2'b10,
        ACC_LONG_ALT = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE,
        ST_BEAT
    } seq_state_e;

    typedef struct packed {
        logic [1:0] psize;
        logic       lane_lo;
        logic       be_rd;
        logic       burst_rd;
        logic       burst_wr;
    } cs_cfg_t;

    typedef struct packed {
        logic [2:0] port_bytes;
        logic [2:0] acc_bytes;
        logic [2:0] beats;
        logic       burst;
        logic [1:0] base;
        logic [1:0] offset;
    } beat_plan_t;

    function automatic logic [2:0] port_width_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd4;
            2'b01:   return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [2:0] access_bytes(input acc_size_e sz);
        case (sz)
            ACC_BYTE: return 3'd1;
            ACC_WORD: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbs_plan.sv
module dbs_plan
    import dbs_pkg::*;
(
    input  cs_cfg_t    cfg,
    input  acc_size_e  size,
    input  logic       write,
    input  logic [1:0] addr_lo,
    output beat_plan_t plan
);

    logic [2:0] pw;
    logic [2:0] ab;
    logic [2:0] nb;

    always_comb begin
        pw = port_width_bytes(cfg.psize);
        ab = access_bytes(size);
        if (ab > pw) begin
            nb = (ab == 3'd4 && pw == 3'd1) ? 3'd4 : 3'd2;
        end else begin
            nb = 3'd1;
        end
        plan.port_bytes = pw;
        plan.acc_bytes  = ab;
        plan.beats      = nb;
        plan.burst      = (nb != 3'd1) && (write ? cfg.burst_wr : cfg.burst_rd);
        plan.base       = cfg.lane_lo ? 2'(3'd4 - pw) : 2'd0;
        plan.offset     = (nb == 3'd1) ? (addr_lo & 2'(pw - 3'd1) & ~2'(ab - 3'd1)) : 2'd0;
    end

endmodule

// File: rtl/dbs_lane_map.sv
module dbs_lane_map
    import dbs_pkg::*;
(
    input  beat_plan_t                     plan,
    input  logic [BEAT_W-1:0]              beat,
    input  logic                           write,
    input  logic                           be_rd,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              dout,
    output logic [LANES-1:0]               lane_en,
    output logic [LANES-1:0]               be,
    output logic [LANES-1:0][BEAT_W-1:0]   lane_byte
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int MSB_IDX = LANES - 1 - i;

        logic              ok_l;
        logic [7:0]        d_l;
        logic [BEAT_W-1:0] j_l;

        always_comb begin
            int p;
            int j;
            int src;
            p    = MSB_IDX - int'(plan.base);
            j    = int'(beat) * int'(plan.port_bytes) + p - int'(plan.offset);
            ok_l = (p >= 0) && (p < int'(plan.port_bytes)) &&
                   (j >= 0) && (j < int'(plan.acc_bytes));
            src  = ok_l ? (int'(plan.acc_bytes) - 1 - j) : 0;
            j_l  = ok_l ? BEAT_W'(j) : '0;
            d_l  = (ok_l && write) ? wdata[8*src +: 8] : 8'h00;
        end

        assign lane_en[i]      = ok_l;
        assign be[i]           = ok_l && (write || be_rd);
        assign lane_byte[i]    = j_l;
        assign dout[8*i +: 8]  = d_l;
    end

endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cfg_port_size,
    input  logic              cfg_lane_low,
    input  logic              cfg_be_on_read,
    input  logic              cfg_burst_rd,
    input  logic              cfg_burst_wr,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_cyc,
    output logic              bus_start,
    output logic              bus_burst,
    output logic              bus_rnw,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic [LANES-1:0]  bus_be,
    input  logic              bus_ack
);

    seq_state_e        st;
    cs_cfg_t           cfg_q;
    logic              write_q;
    acc_size_e         size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BEAT_W-1:0] beat_q;
    logic              first_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_next;

    beat_plan_t                   plan;
    logic [DATA_W-1:0]            map_dout;
    logic [LANES-1:0]             map_en;
    logic [LANES-1:0]             map_be;
    logic [LANES-1:0][BEAT_W-1:0] map_byte;
    logic                         last_beat;

    dbs_plan u_plan (
        .cfg     (cfg_q),
        .size    (size_q),
        .write   (write_q),
        .addr_lo (addr_q[1:0]),
        .plan    (plan)
    );

    dbs_lane_map u_map (
        .plan      (plan),
        .beat      (beat_q),
        .write     (write_q),
        .be_rd     (cfg_q.be_rd),
        .wdata     (wdata_q),
        .dout      (map_dout),
        .lane_en   (map_en),
        .be        (map_be),
        .lane_byte (map_byte)
    );

    assign last_beat = (beat_q == BEAT_W'(plan.beats - 3'd1));

    always_comb begin
        acc_next = acc_q;
        for (int i = 0; i < LANES; i++) begin
            if (map_en[i]) begin
                acc_next[8*(int'(plan.acc_bytes) - 1 - int'(map_byte[i])) +: 8] = bus_din[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cfg_q   <= '0;
            write_q <= 1'b0;
            size_q  <= ACC_BYTE;
            addr_q  <= '0;
            wdata_q <= '0;
            beat_q  <= '0;
            first_q <= 1'b0;
            acc_q   <= '0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cfg_q   <= '{psize:    cfg_port_size,
                                     lane_lo:  cfg_lane_low,
                                     be_rd:    cfg_be_on_read,
                                     burst_rd: cfg_burst_rd,
                                     burst_wr: cfg_burst_wr};
                        write_q <= req_write;
                        size_q  <= acc_size_e'(req_size);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        beat_q  <= '0;
                        first_q <= 1'b1;
                        acc_q   <= '0;
                        st      <= ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    first_q <= 1'b0;
                    if (bus_ack) begin
                        acc_q <= acc_next;
                        if (last_beat) begin
                            st    <= ST_IDLE;
                            done  <= 1'b1;
                            rdata <= write_q ? '0 : acc_next;
                        end else begin
                            beat_q  <= beat_q + 1'b1;
                            first_q <= !plan.burst;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign bus_cyc   = (st == ST_BEAT);
    assign bus_start = bus_cyc && first_q;
    assign bus_burst = bus_cyc && plan.burst;
    assign bus_rnw   = bus_cyc ? !write_q : 1'b1;
    assign bus_addr  = addr_q + ADDR_W'(beat_q) * ADDR_W'(plan.port_bytes);
    assign bus_dout  = bus_cyc ? map_dout : '0;
    assign bus_be    = bus_cyc ? map_be : '0;

endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk
    import dbs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             done,
    input logic             bus_cyc,
    input logic             bus_start,
    input logic             bus_burst,
    input logic             bus_rnw,
    input logic [LANES-1:0] bus_be,
    input logic             bus_ack,
    input logic             be_rd_q
);

    assert_start_in_beat_R4: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> bus_cyc);

    assert_burst_single_start_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_burst && $past(bus_cyc)) |-> !bus_start);

    assert_read_strobes_off_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_rnw && !be_rd_q) |-> (bus_be == '0));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_cyc && bus_ack));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_cyc |-> (bus_be == '0 && !bus_start && !bus_burst));

    assert_ready_idle_R12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_cyc);

endmodule

bind dbs_sequencer dbs_sequencer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .done      (done),
    .bus_cyc   (bus_cyc),
    .bus_start (bus_start),
    .bus_burst (bus_burst),
    .bus_rnw   (bus_rnw),
    .bus_be    (bus_be),
    .bus_ack   (bus_ack),
    .be_rd_q   (cfg_q.be_rd)
);

// File: tb/tb_dbs_sequencer.sv
module tb_dbs_sequencer;
    import dbs_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cfg_port_size = '0;
    logic        cfg_lane_low = 1'b0;
    logic        cfg_be_on_read = 1'b0;
    logic        cfg_burst_rd = 1'b0;
    logic        cfg_burst_wr = 1'b0;
    logic        done;
    logic [31:0] rdata;
    logic        bus_cyc, bus_start, bus_burst, bus_rnw;
    logic [31:0] bus_addr, bus_dout, bus_din;
    logic [3:0]  bus_be;
    logic        ack_r = 1'b0;

    always #5 clk = ~clk;

    dbs_sequencer #(.ADDR_W(32)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .cfg_port_size(cfg_port_size), .cfg_lane_low(cfg_lane_low),
        .cfg_be_on_read(cfg_be_on_read), .cfg_burst_rd(cfg_burst_rd),
        .cfg_burst_wr(cfg_burst_wr),
        .done(done), .rdata(rdata),
        .bus_cyc(bus_cyc), .bus_start(bus_start), .bus_burst(bus_burst),
        .bus_rnw(bus_rnw), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_be(bus_be), .bus_ack(ack_r)
    );

    function automatic logic [31:0] din_of(input logic [31:0] a);
        return {a[7:0] ^ 8'h3C, a[7:0] ^ 8'h5A, a[7:0] ^ 8'h96, a[7:0] ^ 8'hC3};
    endfunction

    assign bus_din = din_of(bus_addr);

    typedef struct {
        logic [31:0] addr;
        logic        rnw;
        logic [31:0] dout;
        logic [3:0]  be;
        logic        start;
        logic        burst;
        string       tag;
    } exp_beat_t;

    exp_beat_t   beat_q[$];
    logic [31:0] res_q[$];
    string       res_tag[$];
    int checks = 0;
    int errors = 0;
    int pending = 0;
    int wcnt = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: computes the expected beats and result, pushes them, then issues the request
    task automatic issue(input bit wr, input logic [31:0] addr, input logic [1:0] size,
                         input logic [31:0] wdata, input logic [1:0] ps, input bit lo,
                         input bit berd, input bit brd, input bit bwr, input string tag);
        int pw, ab, n, off, base;
        bit bst;
        logic [31:0] res, d;
        pw   = (ps == 2'b00) ? 4 : (ps == 2'b01) ? 1 : 2;
        ab   = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
        n    = (ab > pw) ? ab / pw : 1;
        bst  = (n > 1) && (wr ? bwr : brd);
        off  = (n == 1) ? ((int'(addr[1:0]) % pw) / ab) * ab : 0;
        base = lo ? 4 - pw : 0;
        res  = '0;
        for (int k = 0; k < n; k++) begin
            exp_beat_t b;
            b.addr  = addr + 32'(k * pw);
            b.rnw   = !wr;
            b.dout  = '0;
            b.be    = '0;
            b.start = (k == 0) || !bst;
            b.burst = bst;
            b.tag   = tag;
            d       = din_of(b.addr);
            for (int p = 0; p < pw; p++) begin
                int j, lane;
                j    = (n > 1) ? k * pw + p : p - off;
                lane = 3 - (base + p);
                if (j >= 0 && j < ab) begin
                    if (wr) b.dout[8*lane +: 8] = wdata[8*(ab-1-j) +: 8];
                    if (wr || berd) b.be[lane] = 1'b1;
                    if (!wr) res[8*(ab-1-j) +: 8] = d[8*lane +: 8];
                end
            end
            beat_q.push_back(b);
        end
        res_q.push_back(wr ? 32'h0 : res);
        res_tag.push_back(tag);
        pending++;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid      = 1'b1;
        req_write      = wr;
        req_addr       = addr;
        req_size       = size;
        req_wdata      = wdata;
        cfg_port_size  = ps;
        cfg_lane_low   = lo;
        cfg_be_on_read = berd;
        cfg_burst_rd   = brd;
        cfg_burst_wr   = bwr;
        @(negedge clk);
        req_valid = 1'b0;
        wait (pending == 0);
    endtask

    // Slave model and monitor: one wait cycle per beat, compare beats and results
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_r) begin
                ack_r = 1'b0;
                wcnt  = 0;
            end
            if (bus_cyc) begin
                if (wcnt == 0) begin
                    if (beat_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected extra beat at addr", bus_addr, 32'h0);
                    end else begin
                        exp_beat_t e;
                        e = beat_q.pop_front();
                        check(bus_addr == e.addr, {e.tag, " R8"}, "beat address", bus_addr, e.addr);
                        check(bus_rnw == e.rnw, e.tag, "direction", 32'(bus_rnw), 32'(e.rnw));
                        check(bus_be == e.be, {e.tag, " R7"}, "strobes", 32'(bus_be), 32'(e.be));
                        check(bus_dout == e.dout, {e.tag, " R11"}, "write lanes", bus_dout, e.dout);
                        check(bus_start == e.start, {e.tag, " R4/R5 start"}, "start strobe",
                              32'(bus_start), 32'(e.start));
                        check(bus_burst == e.burst, {e.tag, " R5 burst"}, "burst flag",
                              32'(bus_burst), 32'(e.burst));
                    end
                    wcnt = 1;
                end else begin
                    if (bus_start) check(1'b0, "R4", "start in later beat cycle", 32'h1, 32'h0);
                    ack_r = 1'b1;
                end
            end
            if (done) begin
                if (res_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 32'h1, 32'h0);
                end else begin
                    logic [31:0] er;
                    string t;
                    er = res_q.pop_front();
                    t  = res_tag.pop_front();
                    check(rdata == er, {t, " R9"}, "result data", rdata, er);
                    check(beat_q.size() == 0, {t, " R4"}, "beats left at done",
                          32'(beat_q.size()), 32'h0);
                    pending--;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        check(req_ready == 1'b1, "R12", "ready in reset", 32'(req_ready), 32'h1);
        check(bus_cyc == 1'b0 && done == 1'b0, "R12", "cyc/done in reset",
              32'({bus_cyc, done}), 32'h0);
        check(bus_be == 4'h0, "R12", "strobes in reset", 32'(bus_be), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(bus_cyc == 1'b0 && bus_start == 1'b0 && bus_burst == 1'b0, "R11",
              "idle outputs", 32'({bus_cyc, bus_start, bus_burst}), 32'h0);

        //    wr  addr          size   wdata          ps     lo berd brd bwr tag
        issue(1, 32'h0000_0100, 2'b10, 32'hA1B2C3D4, 2'b00, 0, 0, 0, 0, "R1 long write 32");
        issue(0, 32'h0000_0104, 2'b10, 32'h0,        2'b00, 0, 0, 0, 0, "R1 R7 long read 32 no-be");
        issue(0, 32'h0000_0108, 2'b10, 32'h0,        2'b00, 0, 1, 1, 1, "R7 long read 32 be");
        issue(1, 32'h0000_0040, 2'b10, 32'h11223344, 2'b01, 0, 0, 0, 0, "R2 R4 R8 split 8hi");
        issue(1, 32'h0000_0050, 2'b10, 32'h55667788, 2'b01, 1, 0, 0, 1, "R2 R5 burst 8lo");
        issue(0, 32'h0000_0060, 2'b10, 32'h0,        2'b01, 1, 1, 0, 1, "R6 R4 read split 8lo");
        issue(0, 32'h0000_0070, 2'b10, 32'h0,        2'b11, 0, 1, 1, 0, "R3 R5 read burst 16hi");
        issue(1, 32'h0000_0080, 2'b11, 32'h99AABBCC, 2'b10, 1, 0, 1, 0, "R3 R6 write split 16lo");
        issue(0, 32'h0000_0090, 2'b01, 32'h0,        2'b01, 0, 1, 1, 1, "R5 word burst 8hi");
        issue(1, 32'h0000_0102, 2'b00, 32'h0000005E, 2'b00, 0, 0, 1, 1, "R10 byte write 32");
        issue(0, 32'h0000_0202, 2'b01, 32'h0,        2'b10, 1, 1, 1, 1, "R10 word read 16lo");
        issue(1, 32'h0000_0302, 2'b01, 32'h0000ABCD, 2'b00, 0, 0, 1, 1, "R10 word write 32");
        issue(0, 32'h0000_0033, 2'b00, 32'h0,        2'b01, 1, 0, 1, 1, "R10 R7 byte read 8lo");
        issue(0, 32'h0000_0120, 2'b10, 32'h0,        2'b11, 1, 0, 0, 0, "R3 R8 read split 16lo");

        @(negedge clk);
        check(bus_cyc == 1'b0 && bus_be == 4'h0, "R11", "idle after traffic",
              32'({bus_cyc, bus_be}), 32'h0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule